// File: doc/BRIEF.md
# DMA Transfer Address Generator

This block keeps the current source and destination addresses of one DMA channel and steps them after each completed transfer unit. Each side follows its own mode: it stays fixed, counts up or counts down. The step size comes from the programmed transfer size, from single bytes up to 32-byte bursts. A control word selects both modes, the transfer size, the single-address direction and the acknowledge polarity.

A channel sequencer pulses `load_stb` with the start addresses. It then pulses `xfer_done` once for each finished unit and drives the current addresses onto the bus. In a single-address transfer one side is an external device that has no address. That side's mode is ignored and its address stays where it is. The block also shapes a raw acknowledge request into an output of the programmed polarity. It raises a sticky flag when a side that is in use is given the forbidden mode code.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, both addresses are reset to 0 and `cfg_err` is reset to 0.
- R2: A cycle with `load_stb` high puts `src_init` and `dst_init` into `src_addr` and `dst_addr` at the next edge. This takes priority over a `xfer_done` pulse in the same cycle.
- R3: Addresses change only at an edge where `xfer_done` is high. Both sides step at that same edge, and with `xfer_done` low they hold their values.
- R4: Mode field codes: 00 keeps the address fixed, 01 adds the step and 10 subtracts the step. Arithmetic wraps modulo 2^32.
- R5: Size field `ctrl_word[6:4]` gives the step: 0→1, 1→2, 2→4, 3→8, 4→32 (32-byte burst). Codes 5 to 7 give a step of 0.
- R6: The source mode is in `ctrl_word[1:0]` and the destination mode is in `ctrl_word[3:2]`. If a side in use has mode 11, its address is held on `xfer_done`. The other side still steps. `cfg_err` goes high at the next edge and stays high.
- R7: A `load_stb` cycle clears `cfg_err` at the next edge. It is set again at a later edge only if a side in use still has mode 11.
- R8: Direction field `ctrl_word[8:7]`: 01 (memory to device) ignores the destination mode, and 10 (device to memory) ignores the source mode. The ignored side is never updated and never raises `cfg_err`. Codes 00 and 11 use both sides.
- R9: `ctrl_word[9]` = 0 makes `ack_out` follow `ack_req` (active-high). A value of 1 makes `ack_out` the inverse of `ack_req` (active-low). With `ack_req` low, `ack_out` sits at its inactive level without any clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 10 | Channel control: modes, size, direction, ack polarity |
| load_stb | input | 1 | Load start addresses, clears error |
| src_init | input | 32 | Initial source address |
| dst_init | input | 32 | Initial destination address |
| xfer_done | input | 1 | One transfer unit finished |
| ack_req | input | 1 | Raw acknowledge request |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| ack_out | output | 1 | Polarity-adjusted acknowledge |
| cfg_err | output | 1 | Sticky forbidden-mode flag |

## Verification
Every size code is run with the source counting up and the destination counting down. A swapped step entry or a swapped direction therefore shows as a wrong value on one side. Start addresses next to 0 and 2^32 separate true modulo wrap from any saturation. Runs with a forbidden mode on one side show that only that side freezes, and repeating them under each single-address direction shows that the ignore rule masks both the update and the error. Coincident load and done, plus idle cycles with no done pulse, check update priority and timing. Both ack polarities are tried with the request high and low.

// File: rtl/dma_addr_pkg.sv
// Package: shared field layout and encodings for the DMA address generator.
// Assumes a 10-bit control word; field positions are fixed here so that the
// decoder and the bench agree on them.
package dma_addr_pkg;

    // Address update mode of one side.
    typedef enum logic [1:0] {
        AMODE_HOLD = 2'b00,
        AMODE_UP   = 2'b01,
        AMODE_DOWN = 2'b10,
        AMODE_BAD  = 2'b11
    } addr_mode_e;

    // Transfer unit size.
    typedef enum logic [2:0] {
        USZ_B1   = 3'd0,
        USZ_B2   = 3'd1,
        USZ_B4   = 3'd2,
        USZ_B8   = 3'd3,
        USZ_B32  = 3'd4,
        USZ_R5   = 3'd5,
        USZ_R6   = 3'd6,
        USZ_R7   = 3'd7
    } unit_size_e;

    // Single-address direction.
    typedef enum logic [1:0] {
        SDIR_DUAL   = 2'b00,
        SDIR_MEM2IO = 2'b01,
        SDIR_IO2MEM = 2'b10,
        SDIR_DUAL2  = 2'b11
    } single_dir_e;

    localparam int CTRL_W = 10;
    localparam int STEP_W = 6;

    // Decoded view of the control word.
    typedef struct packed {
        logic        ack_low;
        single_dir_e sdir;
        unit_size_e  usize;
        addr_mode_e  dmode;
        addr_mode_e  smode;
    } chan_ctrl_t;

endpackage

// File: rtl/dma_step_decode.sv
// Module: dma_step_decode
// Turns the transfer size code into an unsigned step magnitude.
// Assumes reserved size codes must not move the address (step 0).
module dma_step_decode
    import dma_addr_pkg::*;
(
    input  unit_size_e        usize,
    output logic [STEP_W-1:0] step
);

    // Purpose: look up the per-unit byte step.
    always_comb begin
        case (usize)
            USZ_B1:  step = STEP_W'(1);
            USZ_B2:  step = STEP_W'(2);
            USZ_B4:  step = STEP_W'(4);
            USZ_B8:  step = STEP_W'(8);
            USZ_B32: step = STEP_W'(32);
            default: step = '0;
        endcase
    end

endmodule

// File: rtl/dma_addr_side.sv
// Module: dma_addr_side
// Holds the address register of one side (source or destination). It loads
// it, or steps it up or down on a done pulse according to its mode.
// Assumes: load beats done; an ignored side or forbidden mode holds the value.
module dma_addr_side
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  addr_mode_e        mode,
    input  logic              ignore,
    input  logic [STEP_W-1:0] step,
    input  logic              load,
    input  logic [ADDR_W-1:0] init,
    input  logic              done,
    output logic [ADDR_W-1:0] addr,
    output logic              bad
);

    logic [ADDR_W-1:0] step_ext;
    logic [ADDR_W-1:0] next_addr;

    assign step_ext = ADDR_W'(step);

    // Purpose: flag a forbidden mode only while this side is in use.
    assign bad = !ignore && (mode == AMODE_BAD);

    // Purpose: compute the stepped address for the current mode.
    always_comb begin
        next_addr = addr;
        if (!ignore) begin
            case (mode)
                AMODE_UP:   next_addr = addr + step_ext;
                AMODE_DOWN: next_addr = addr - step_ext;
                default:    next_addr = addr;
            endcase
        end
    end

    // Purpose: address register with reset, load priority and done update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= init;
        else if (done)
            addr <= next_addr;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past(init)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done) |=> $stable(addr)); // R3
    AST_BAD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done && !ignore && mode == AMODE_BAD) |=> $stable(addr)); // R6
    AST_IGNORED_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ignore) |=> $stable(addr)); // R8
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done && !ignore && mode == AMODE_UP)
        |=> addr == $past(addr) + ADDR_W'($past(step))); // R4

endmodule

// File: rtl/dma_ack_shape.sv
// Module: dma_ack_shape
// Applies the programmed polarity to the raw acknowledge request.
// Assumes a combinational path is acceptable (no extra cycle of latency).
module dma_ack_shape (
    input  logic ack_req,
    input  logic ack_low,
    output logic ack_out
);

    // Purpose: active-high passes the request, active-low inverts it.
    always_comb begin
        if (ack_low)
            ack_out = !ack_req;
        else
            ack_out = ack_req;
    end

endmodule

// File: rtl/dma_addr_gen.sv
// Module: dma_addr_gen (top)
// Address generator for one DMA channel: source and destination registers,
// step decode, single-address masking, sticky config error, ack polarity.
// Assumes the control word is stable while transfers run.
module dma_addr_gen
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              load_stb,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic              xfer_done,
    input  logic              ack_req,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              ack_out,
    output logic              cfg_err
);

    localparam int NSIDE = 2;

    chan_ctrl_t        ctl;
    logic [STEP_W-1:0] step;
    addr_mode_e        side_mode [NSIDE];
    logic              side_ign  [NSIDE];
    logic [ADDR_W-1:0] side_init [NSIDE];
    logic [ADDR_W-1:0] side_addr [NSIDE];
    logic              side_bad  [NSIDE];
    logic              any_bad;

    assign ctl = chan_ctrl_t'(ctrl_word);

    dma_step_decode u_step (
        .usize (ctl.usize),
        .step  (step)
    );

    // Purpose: route per-side mode, ignore and start address (0=src, 1=dst).
    always_comb begin
        side_mode[0] = ctl.smode;
        side_mode[1] = ctl.dmode;
        side_ign[0]  = (ctl.sdir == SDIR_IO2MEM);
        side_ign[1]  = (ctl.sdir == SDIR_MEM2IO);
        side_init[0] = src_init;
        side_init[1] = dst_init;
    end

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_addr_side #(.ADDR_W(ADDR_W)) u_side (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (side_mode[g]),
            .ignore (side_ign[g]),
            .step   (step),
            .load   (load_stb),
            .init   (side_init[g]),
            .done   (xfer_done),
            .addr   (side_addr[g]),
            .bad    (side_bad[g])
        );
    end

    assign src_addr = side_addr[0];
    assign dst_addr = side_addr[1];
    assign any_bad  = side_bad[0] || side_bad[1];

    // Purpose: sticky error, cleared by a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else if (load_stb)
            cfg_err <= 1'b0;
        else if (any_bad)
            cfg_err <= 1'b1;
    end

    dma_ack_shape u_ack (
        .ack_req (ack_req),
        .ack_low (ctl.ack_low),
        .ack_out (ack_out)
    );

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !load_stb) |=> cfg_err); // R6
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !cfg_err); // R7
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |-> ack_out == ctrl_word[9]); // R9
    AST_IGN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_err && !load_stb && ctrl_word[8:7] == 2'b01
         && ctrl_word[1:0] != 2'b11) |=> !cfg_err); // R8

endmodule

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  ctrl_word;
    logic        load_stb;
    logic [31:0] src_init, dst_init;
    logic        xfer_done;
    logic        ack_req;
    logic [31:0] src_addr, dst_addr;
    logic        ack_out, cfg_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    dma_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .load_stb(load_stb),
        .src_init(src_init), .dst_init(dst_init), .xfer_done(xfer_done),
        .ack_req(ack_req), .src_addr(src_addr), .dst_addr(dst_addr),
        .ack_out(ack_out), .cfg_err(cfg_err)
    );

    function automatic logic [9:0] mk(input logic [1:0] sm, input logic [1:0] dm,
                                      input logic [2:0] sz, input logic [1:0] dir,
                                      input logic pol);
        return {pol, dir, sz, dm, sm};
    endfunction

    function automatic logic [31:0] step_of(input int sz);
        case (sz)
            0: return 32'd1;
            1: return 32'd2;
            2: return 32'd4;
            3: return 32'd8;
            4: return 32'd32;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One edge with the given strobes; sample after it.
    task automatic cyc(input logic ld, input logic dn);
        load_stb  = ld;
        xfer_done = dn;
        @(negedge clk);
        load_stb  = 1'b0;
        xfer_done = 1'b0;
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] d);
        src_init = s;
        dst_init = d;
        cyc(1'b1, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ctrl_word = '0; load_stb = 0; xfer_done = 0; ack_req = 0;
        src_init = 32'hDEAD_BEEF; dst_init = 32'h1234_5678;
        @(negedge clk); @(negedge clk);
        chk("R1 src reset", src_addr, 32'h0);
        chk("R1 dst reset", dst_addr, 32'h0);
        chk("R1 err reset", {31'b0, cfg_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_load();
        load(32'h0000_1000, 32'h0000_2000);
        chk("R2 src load", src_addr, 32'h0000_1000);
        chk("R2 dst load", dst_addr, 32'h0000_2000);
    endtask

    task automatic t_sizes();
        for (int sz = 0; sz < 8; sz++) begin
            ctrl_word = mk(2'b01, 2'b10, 3'(sz), 2'b00, 1'b0);
            load(32'h0000_4000, 32'h0000_8000);
            cyc(1'b0, 1'b1);
            chk($sformatf("R5 R4 src up size%0d", sz), src_addr, 32'h4000 + step_of(sz));
            chk($sformatf("R5 R4 dst down size%0d", sz), dst_addr, 32'h8000 - step_of(sz));
        end
    endtask

    task automatic t_no_done();
        ctrl_word = mk(2'b01, 2'b01, 3'd2, 2'b00, 1'b0);
        load(32'h100, 32'h200);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        chk("R3 src held without done", src_addr, 32'h100);
        chk("R3 dst held without done", dst_addr, 32'h200);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        chk("R3 src two dones", src_addr, 32'h108);
        chk("R3 dst two dones", dst_addr, 32'h208);
    endtask

    task automatic t_fixed_wrap();
        ctrl_word = mk(2'b00, 2'b00, 3'd4, 2'b00, 1'b0);
        load(32'h55, 32'h66);
        cyc(1'b0, 1'b1);
        chk("R4 src fixed", src_addr, 32'h55);
        chk("R4 dst fixed", dst_addr, 32'h66);
        ctrl_word = mk(2'b01, 2'b10, 3'd2, 2'b00, 1'b0);
        load(32'hFFFF_FFFE, 32'h0000_0001);
        cyc(1'b0, 1'b1);
        chk("R4 src wrap up", src_addr, 32'h0000_0002);
        chk("R4 dst wrap down", dst_addr, 32'hFFFF_FFFD);
    endtask

    task automatic t_priority();
        ctrl_word = mk(2'b01, 2'b01, 3'd0, 2'b00, 1'b0);
        load(32'h10, 32'h20);
        src_init = 32'hA0; dst_init = 32'hB0;
        cyc(1'b1, 1'b1);
        chk("R2 load beats done src", src_addr, 32'hA0);
        chk("R2 load beats done dst", dst_addr, 32'hB0);
    endtask

    task automatic t_bad_mode();
        ctrl_word = mk(2'b00, 2'b00, 3'd2, 2'b00, 1'b0);
        load(32'h300, 32'h400);
        chk("R7 err clear after load", {31'b0, cfg_err}, 32'h0);
        ctrl_word = mk(2'b11, 2'b01, 3'd2, 2'b00, 1'b0);
        cyc(1'b0, 1'b1);
        chk("R6 src frozen", src_addr, 32'h300);
        chk("R6 dst still steps", dst_addr, 32'h404);
        chk("R6 err set", {31'b0, cfg_err}, 32'h1);
        ctrl_word = mk(2'b00, 2'b00, 3'd2, 2'b00, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        chk("R6 err sticky", {31'b0, cfg_err}, 32'h1);
        load(32'h300, 32'h400);
        chk("R7 load clears err", {31'b0, cfg_err}, 32'h0);
        ctrl_word = mk(2'b01, 2'b11, 3'd2, 2'b00, 1'b0);
        load(32'h300, 32'h400);
        chk("R7 cleared on load cycle", {31'b0, cfg_err}, 32'h0);
        cyc(1'b0, 1'b1);
        chk("R7 reset again while bad", {31'b0, cfg_err}, 32'h1);
        chk("R6 dst frozen", dst_addr, 32'h400);
        chk("R6 src steps", src_addr, 32'h304);
    endtask

    task automatic t_single();
        ctrl_word = mk(2'b01, 2'b11, 3'd3, 2'b01, 1'b0);
        load(32'h1000, 32'h2000);
        cyc(1'b0, 1'b1);
        chk("R8 mem2io src steps", src_addr, 32'h1008);
        chk("R8 mem2io dst ignored", dst_addr, 32'h2000);
        chk("R8 mem2io no err", {31'b0, cfg_err}, 32'h0);
        ctrl_word = mk(2'b11, 2'b10, 3'd3, 2'b10, 1'b0);
        load(32'h1000, 32'h2000);
        cyc(1'b0, 1'b1);
        chk("R8 io2mem src ignored", src_addr, 32'h1000);
        chk("R8 io2mem dst steps", dst_addr, 32'h1FF8);
        chk("R8 io2mem no err", {31'b0, cfg_err}, 32'h0);
        ctrl_word = mk(2'b01, 2'b01, 3'd1, 2'b11, 1'b0);
        load(32'h1000, 32'h2000);
        cyc(1'b0, 1'b1);
        chk("R8 code 11 dual src", src_addr, 32'h1002);
        chk("R8 code 11 dual dst", dst_addr, 32'h2002);
    endtask

    task automatic t_ack();
        ctrl_word = mk(2'b00, 2'b00, 3'd0, 2'b00, 1'b0);
        ack_req = 1'b0; #1;
        chk("R9 high pol idle", {31'b0, ack_out}, 32'h0);
        ack_req = 1'b1; #1;
        chk("R9 high pol active", {31'b0, ack_out}, 32'h1);
        ctrl_word = mk(2'b00, 2'b00, 3'd0, 2'b00, 1'b1);
        #1;
        chk("R9 low pol active", {31'b0, ack_out}, 32'h0);
        ack_req = 1'b0; #1;
        chk("R9 low pol idle", {31'b0, ack_out}, 32'h1);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_load();
        t_sizes();
        t_no_done();
        t_fixed_wrap();
        t_priority();
        t_bad_mode();
        t_single();
        t_ack();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule